// File: doc/BRIEF.md
# Legacy Window Shadow Attribute Router

This block steers every memory access that falls in the top 256 KB of the first megabyte (C0000h to FFFFFh). That range is split into thirteen segments: one 64 KB segment at the top and twelve 16 KB segments below it. Each segment carries a 4-bit attribute with a read-enable bit and a write-enable bit. A read in a segment whose read-enable is set goes to system DRAM. A read in a segment whose read-enable is clear goes to the forward port, which leads to ROM or the expansion bus. Writes follow the write-enable bit in the same way. Because reads and writes are steered independently, firmware can copy a ROM image into shadow RAM and then switch the segment to serve reads from that RAM.

The attributes are held in seven byte-wide registers, two segment nibbles per byte. They sit at configuration offsets 59h to 5Fh of a byte-wide configuration port that also has per-nibble write enables. The decode is purely combinational. The block raises exactly one of two selects for each valid access and passes the address, write flag, data and byte enables through unchanged. Any access below C0000h goes to DRAM.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset all seven attribute bytes read back as 00h, and every access inside C0000h..FFFFFh goes to the forward port.
- R2: A configuration read at offset 59h+k (k = 0..6) returns the byte stored there. Segment index i is held in the register at offset 59h + i/2: an even index uses bits [3:0] and an odd index uses bits [7:4].
- R3: On a configuration write, `cfg_nib_en[0]` enables the update of bits [3:0] and `cfg_nib_en[1]` enables the update of bits [7:4]. A nibble whose enable is clear keeps its old value.
- R4: Within each nibble, bit 0 is the read-enable and bit 1 is the write-enable. Bits 2 and 3 are stored but have no effect on steering.
- R5: Segment index 1 covers F0000h..FFFFFh.
- R6: Segment indices 2 to 13 cover twelve consecutive 16 KB ranges in ascending address order, with index 2 starting at C0000h.
- R7: Segment index 0 maps no address, so its attribute value never affects steering.
- R8: A read inside the window selects DRAM when the read-enable of its segment is set, and selects the forward port otherwise.
- R9: A write inside the window selects DRAM when the write-enable of its segment is set, and selects the forward port otherwise. This does not depend on the read-enable.
- R10: A valid access below C0000h always selects DRAM, whatever the attributes hold.
- R11: While `mem_valid` is high exactly one of `dram_sel` and `fwd_sel` is high. While it is low both are low.
- R12: `out_addr`, `out_write`, `out_wdata` and `out_be` equal `mem_addr`, `mem_write`, `mem_wdata` and `mem_be` in the same cycle.
- R13: Configuration offsets outside 59h..5Fh are ignored: a write there changes no attribute, and a read there returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_nib_en | input | 2 | Nibble write enables: bit 0 for low, bit 1 for high |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr` (combinational) |
| mem_valid | input | 1 | Memory access valid |
| mem_write | input | 1 | 1 for write, 0 for read |
| mem_addr | input | 20 | Byte address of the access |
| mem_wdata | input | 32 | Write data |
| mem_be | input | 4 | Byte enables |
| dram_sel | output | 1 | Access steered to DRAM |
| fwd_sel | output | 1 | Access steered to ROM or expansion bus |
| out_addr | output | 20 | Address passed through |
| out_write | output | 1 | Write flag passed through |
| out_wdata | output | 32 | Write data passed through |
| out_be | output | 4 | Byte enables passed through |

## Verification
The bench enables read access in one segment at a time and probes the first and last byte of all thirteen segments. A decoder with an off-by-one index, or with its segments in reverse order, would therefore light up a neighbour. A decoder that put the 64 KB segment on the wrong nibble would light up the wrong range or none. A nibble-only write must not disturb the other half of its byte; a design that writes the whole byte would wipe the neighbouring segment's attribute. Attributes with only read-enable or only write-enable show whether reads and writes are steered apart; a design that ORs the two bits would send both to DRAM. Writes to the reserved nibble and to offsets just outside the register range must have no effect, and the probes at BFFFFh and C0000h pin down the window edge.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
    localparam int ATTR_REGS = 7;
    localparam int CFG_AW    = 8;
    localparam logic [CFG_AW-1:0] CFG_BASE = 8'h59;
    localparam int SEG_W     = 4;
    localparam int RE_BIT    = 0;
    localparam int WE_BIT    = 1;

    typedef logic [ATTR_REGS-1:0][7:0] attr_bank_t;

    typedef struct packed {
        attr_bank_t bank;
    } attr_state_t;
endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_nib_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output attr_bank_t        bank
);
    localparam int IDX_W = $clog2(ATTR_REGS);

    attr_state_t st_d, st_q;
    logic [CFG_AW-1:0] rel_off;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        rel_off = cfg_addr - CFG_BASE;
        hit     = (cfg_addr >= CFG_BASE) && (rel_off < CFG_AW'(ATTR_REGS));
        idx     = rel_off[IDX_W-1:0];
        st_d    = st_q;
        if (cfg_wr_en && hit) begin
            if (cfg_nib_en[0]) st_d.bank[idx][3:0] = cfg_wdata[3:0];
            if (cfg_nib_en[1]) st_d.bank[idx][7:4] = cfg_wdata[7:4];
        end
        cfg_rdata = hit ? st_q.bank[idx] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;

    // R13: a write to an offset outside the bank leaves every attribute as it was
    p_ignore_offset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !hit) |=> $stable(st_q.bank));

    // R3: with the high enable clear, the high nibble of the target byte holds
    p_keep_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && hit && !cfg_nib_en[1]) |=>
        (st_q.bank[$past(idx)][7:4] == $past(st_q.bank[idx][7:4])));

    // R3: with the low enable clear, the low nibble of the target byte holds
    p_keep_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && hit && !cfg_nib_en[0]) |=>
        (st_q.bank[$past(idx)][3:0] == $past(st_q.bank[idx][3:0])));
endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int SMALL_W = 14,
    parameter int LARGE_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [SEG_W-1:0]  seg_idx
);
    localparam int SUB_W = ADDR_W - 2 - SMALL_W;

    logic top_seg;
    logic [SUB_W-1:0] sub;

    always_comb begin
        in_win  = &addr[ADDR_W-1:ADDR_W-2];
        top_seg = &addr[ADDR_W-1:LARGE_W];
        sub     = addr[ADDR_W-3:SMALL_W];
        if (!in_win)      seg_idx = '0;
        else if (top_seg) seg_idx = SEG_W'(1);
        else              seg_idx = SEG_W'(sub) + SEG_W'(2);
    end

    // R7: no address in the window resolves to the reserved index
    always_comb begin
        if (in_win) begin
            p_no_reserved_r7: assert (seg_idx != '0 && seg_idx <= SEG_W'(2 * ATTR_REGS - 1));
        end
    end
endmodule

// File: rtl/shadow_steer.sv
module shadow_steer
    import shadow_attr_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic       in_win,
    input  logic [3:0] attr,
    output logic       dram_sel,
    output logic       fwd_sel
);
    logic allow;

    always_comb begin
        allow    = write ? attr[WE_BIT] : attr[RE_BIT];
        dram_sel = valid && (!in_win || allow);
        fwd_sel  = valid && in_win && !allow;
    end
endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_nib_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [BE_W-1:0]   mem_be,
    output logic              dram_sel,
    output logic              fwd_sel,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic [DATA_W-1:0] out_wdata,
    output logic [BE_W-1:0]   out_be
);
    attr_bank_t       bank;
    logic             in_win;
    logic [SEG_W-1:0] seg_idx;
    logic [3:0]       seg_attr;
    logic [7:0]       seg_byte;

    shadow_attr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_nib_en(cfg_nib_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bank      (bank)
    );

    shadow_seg_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .addr   (mem_addr),
        .in_win (in_win),
        .seg_idx(seg_idx)
    );

    always_comb begin
        seg_byte = bank[seg_idx[SEG_W-1:1]];
        seg_attr = seg_idx[0] ? seg_byte[7:4] : seg_byte[3:0];
    end

    shadow_steer u_steer (
        .valid   (mem_valid),
        .write   (mem_write),
        .in_win  (in_win),
        .attr    (seg_attr),
        .dram_sel(dram_sel),
        .fwd_sel (fwd_sel)
    );

    assign out_addr  = mem_addr;
    assign out_write = mem_write;
    assign out_wdata = mem_wdata;
    assign out_be    = mem_be;

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $onehot({dram_sel, fwd_sel}));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> !(dram_sel || fwd_sel));

    p_below_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !in_win) |-> dram_sel);

    p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_addr == mem_addr) && (out_wdata == mem_wdata) && (out_be == mem_be));
endmodule

// File: tb/shadow_attr_router_bench.sv
module shadow_attr_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_nib_en = 2'b00;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        mem_valid = 1'b0;
    logic        mem_write = 1'b0;
    logic [19:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [3:0]  mem_be = '0;
    logic        dram_sel, fwd_sel, out_write;
    logic [19:0] out_addr;
    logic [31:0] out_wdata;
    logic [3:0]  out_be;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [7];

    always #5 clk = ~clk;

    shadow_attr_router u_shadow_attr_router (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] off, logic [7:0] data, logic [1:0] nib);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = data; cfg_nib_en = nib;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_nib_en = 2'b00;
        if (off >= 8'h59 && off <= 8'h5F) begin
            if (nib[0]) model[off - 8'h59][3:0] = data[3:0];
            if (nib[1]) model[off - 8'h59][7:4] = data[7:4];
        end
    endtask

    task automatic cfg_check(logic [7:0] off, logic [7:0] exp, string req);
        @(negedge clk);
        cfg_addr = off;
        #1;
        chk(req, cfg_rdata, exp, $sformatf("rdata@%h", off));
    endtask

    task automatic set_seg(int s, logic [3:0] val);
        cfg_write(8'(8'h59 + s / 2), {val, val}, (s % 2) ? 2'b10 : 2'b01);
    endtask

    task automatic clear_all();
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00, 2'b11);
    endtask

    function automatic int seg_of(logic [19:0] a);
        if (a < 20'hC0000) return -1;
        if (a >= 20'hF0000) return 1;
        return 2 + int'((a - 20'hC0000) >> 14);
    endfunction

    function automatic logic [19:0] seg_start(int s);
        return (s == 1) ? 20'hF0000 : 20'(20'hC0000 + (s - 2) * 20'h4000);
    endfunction

    function automatic logic [19:0] seg_end(int s);
        return (s == 1) ? 20'hFFFFF : 20'(seg_start(s) + 20'h3FFF);
    endfunction

    task automatic route(logic [19:0] a, logic wr, string req);
        logic [7:0] b;
        logic [3:0] n;
        logic exp_d;
        int s;
        @(negedge clk);
        mem_valid = 1'b1; mem_write = wr; mem_addr = a;
        #1;
        s = seg_of(a);
        if (s < 0) exp_d = 1'b1;
        else begin
            b = model[s / 2];
            n = (s % 2) ? b[7:4] : b[3:0];
            exp_d = wr ? n[1] : n[0];
        end
        chk(req, {31'b0, dram_sel}, {31'b0, exp_d}, $sformatf("dram_sel a=%h wr=%0d", a, wr));
        chk(req, {31'b0, fwd_sel}, {31'b0, ~exp_d}, $sformatf("fwd_sel a=%h wr=%0d", a, wr));
        mem_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), 8'h00, "R1");
        route(20'hC0000, 1'b0, "R1");
        route(20'hF8000, 1'b1, "R1");
    endtask

    task automatic t_readback();
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'(8'hA1 + k * 8'h11), 2'b11);
        for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), 8'(8'hA1 + k * 8'h11), "R2");
    endtask

    task automatic t_nibble();
        cfg_write(8'h5A, 8'h3C, 2'b01);
        cfg_check(8'h5A, model[1], "R3");
        chk("R3", model[1], 8'hBC, "model low-only");
        cfg_write(8'h5A, 8'h7E, 2'b10);
        cfg_check(8'h5A, 8'h7C, "R3");
        cfg_write(8'h5B, 8'hFF, 2'b00);
        cfg_check(8'h5B, model[2], "R3");
    endtask

    task automatic t_outside();
        clear_all();
        cfg_write(8'h58, 8'hFF, 2'b11);
        cfg_write(8'h60, 8'hFF, 2'b11);
        cfg_check(8'h58, 8'h00, "R13");
        cfg_check(8'h60, 8'h00, "R13");
        for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), 8'h00, "R13");
        route(20'hC0000, 1'b0, "R13");
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00, 2'b11);
        route(20'h00000, 1'b0, "R10");
        route(20'hBFFFF, 1'b1, "R10");
        route(20'h9A000, 1'b0, "R10");
    endtask

    task automatic t_segmap();
        clear_all();
        for (int s = 1; s <= 13; s++) begin
            set_seg(s, 4'h1);
            for (int p = 1; p <= 13; p++) begin
                route(seg_start(p), 1'b0, (s == 1) ? "R5" : "R6");
                route(seg_end(p), 1'b0, "R8");
            end
            set_seg(s, 4'h0);
        end
        // R4: upper bits of a nibble do not steer
        set_seg(3, 4'hC);
        route(seg_start(3), 1'b0, "R4");
        route(seg_start(3), 1'b1, "R4");
        set_seg(3, 4'h0);
    endtask

    task automatic t_indep();
        set_seg(5, 4'h2);
        route(seg_start(5), 1'b0, "R9");
        route(seg_start(5), 1'b1, "R9");
        set_seg(5, 4'h1);
        route(seg_end(5), 1'b0, "R8");
        route(seg_end(5), 1'b1, "R9");
        set_seg(1, 4'h3);
        route(20'hFFFFF, 1'b0, "R8");
        route(20'hF0000, 1'b1, "R9");
        clear_all();
    endtask

    task automatic t_reserved();
        set_seg(0, 4'h3);
        cfg_check(8'h59, 8'h03, "R7");
        for (int p = 1; p <= 13; p++) begin
            route(seg_start(p), 1'b0, "R7");
            route(seg_end(p), 1'b1, "R7");
        end
        clear_all();
    endtask

    task automatic t_idle_pass();
        @(negedge clk);
        mem_valid = 1'b0; mem_write = 1'b1; mem_addr = 20'hC4000;
        mem_wdata = 32'hDEAD_BEEF; mem_be = 4'b1010;
        #1;
        chk("R11", {30'b0, dram_sel, fwd_sel}, 32'h0, "idle selects");
        chk("R12", out_addr, 32'hC4000, "out_addr");
        chk("R12", out_wdata, 32'hDEAD_BEEF, "out_wdata");
        chk("R12", out_be, 4'b1010, "out_be");
        chk("R12", out_write, 1'b1, "out_write");
        mem_valid = 1'b1;
        #1;
        chk("R11", {31'b0, dram_sel ^ fwd_sel}, 32'h1, "one-hot select");
        mem_valid = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 7; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_nibble();
        t_outside();
        t_segmap();
        t_indep();
        t_reserved();
        t_idle_pass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule